// File: doc/BRIEF.md
# Three-State Snooping Coherence Controller

This block keeps one processor's small direct-mapped, write-back cache coherent with its peers on a shared snooping bus. Each line is held in one of three states: Invalid, Shared (clean copy that may only be read) or Exclusive (the only copy, possibly dirty, readable and writable). Writes use invalidation. A write that does not own the line broadcasts a write miss so that other caches drop their copies. The block turns each processor access into a local hit or into a short series of bus transactions. It also reacts to read misses and write misses that other caches place on the bus.

The processor side is a single request with a busy/done handshake. For its own transactions the block raises a bus request and holds it in a pending state until the external arbiter grants it. Each granted transaction takes one cycle. Memory returns fill data in the grant cycle. When a snooped miss hits an Exclusive line, the dirty block goes out on a separate flush port in the next cycle. Lines hold one word and are indexed by the low address bits.

Top module: `snoop_coh_ctrl`

## Requirements
- R1: After synchronous reset every line is Invalid, and cpu_busy, cpu_done, bus_req and flush_valid are all low.
- R2: A processor read whose line is not valid for that tag, and is not dirty, issues a read miss (bus_cmd 1) at the request address. The granted fill word is returned on cpu_rdata and the line becomes Shared.
- R3: A processor write to a Shared line of the same tag, or to a line that is not dirty under another tag, issues a write miss (bus_cmd 2). On grant the line becomes Exclusive and holds the write data.
- R4: Read hits in Shared or Exclusive and write hits in Exclusive raise no bus request. cpu_done rises in the second cycle after the request is accepted.
- R5: A snooped write miss (snp_is_wr 1) that hits a Shared line invalidates it without a flush. A later read of that address misses.
- R6: A snooped read miss (snp_is_wr 0) that hits a Shared line causes no flush and leaves the line valid.
- R7: A snooped read miss that hits an Exclusive line pulses flush_valid one cycle later with that address and data, and the line becomes Shared. A later write needs a write miss.
- R8: A snooped write miss that hits an Exclusive line flushes it in the same way and leaves the line Invalid.
- R9: A processor miss on an index whose line is Exclusive under another tag first issues a write-back (bus_cmd 3) carrying the old address and data. The read miss or write miss follows only after that grant.
- R10: bus_req, with its bus_cmd and bus_addr, stays asserted and unchanged until bus_gnt unless a snoop intervenes. bus_cmd encodes read miss 1, write miss 2 and write-back 3.
- R11: A request is accepted only while cpu_busy is low. cpu_busy then stays high until the one-cycle cpu_done pulse, in which cpu_rdata is valid for reads.
- R12: A snoop to the index of a waiting processor access takes precedence, and bus_req is low in that cycle. If the snoop flushes a line that was waiting for write-back, that write-back is dropped and the miss follows directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor access request |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_busy | output | 1 | Access in progress |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Read result, valid with cpu_done |
| bus_req | output | 1 | Bus request |
| bus_cmd | output | 2 | 1 read miss, 2 write miss, 3 write-back |
| bus_addr | output | ADDR_W | Transaction address |
| bus_wdata | output | DATA_W | Write-back data |
| bus_gnt | input | 1 | Grant; transaction completes in this cycle |
| bus_rdata | input | DATA_W | Fill data in the grant cycle |
| snp_valid | input | 1 | Snooped transaction from another cache |
| snp_is_wr | input | 1 | 1 write miss, 0 read miss |
| snp_addr | input | ADDR_W | Snooped address |
| flush_valid | output | 1 | Dirty block supplied to the bus |
| flush_addr | output | ADDR_W | Flushed address |
| flush_data | output | DATA_W | Flushed data |

## Verification
A line left in the wrong state does not show at the ports right away. It appears at the next access to that index. A stale Shared line shows as a missing write miss, or as a read hit where a miss was due. A line wrongly left Exclusive shows as a spurious flush or an extra write-back. The bench therefore follows every snoop with a processor access to the same address, so that each hidden state change surfaces within a few cycles. A broken pending state shows at once as a dropped, reordered or repeated bus command.

// File: rtl/snoop_coh_pkg.sv
`timescale 1ns/1ps
package snoop_coh_pkg;
    typedef enum logic [1:0] {
        LN_INV = 2'd0,
        LN_SHR = 2'd1,
        LN_EXC = 2'd2
    } line_st_e;

    typedef enum logic [1:0] {
        BC_IDLE   = 2'd0,
        BC_RDMISS = 2'd1,
        BC_WRMISS = 2'd2,
        BC_WRBACK = 2'd3
    } bus_cmd_e;

    typedef enum logic [2:0] {
        F_IDLE,
        F_CHECK,
        F_PEND_WB,
        F_PEND_RD,
        F_PEND_WM
    } fsm_e;
endpackage

// File: rtl/snp_line_array.sv
`timescale 1ns/1ps
// Line storage plus snoop response (invalidate / flush).
module snp_line_array
    import snoop_coh_pkg::*;
#(
    parameter int LINES  = 8,
    parameter int IDX_W  = 3,
    parameter int TAG_W  = 5,
    parameter int DATA_W = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [IDX_W-1:0]        rd_idx,
    output line_st_e                rd_st,
    output logic [TAG_W-1:0]        rd_tag,
    output logic [DATA_W-1:0]       rd_data,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        wr_idx,
    input  line_st_e                wr_st,
    input  logic [TAG_W-1:0]        wr_tag,
    input  logic [DATA_W-1:0]       wr_data,
    input  logic                    snp_valid,
    input  logic                    snp_is_wr,
    input  logic [IDX_W-1:0]        snp_idx,
    input  logic [TAG_W-1:0]        snp_tag,
    output logic                    flush_valid,
    output logic [TAG_W+IDX_W-1:0]  flush_addr,
    output logic [DATA_W-1:0]       flush_data
);
    line_st_e          st_q   [LINES];
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [DATA_W-1:0] data_q [LINES];

    line_st_e snp_st;
    logic     snp_hit;

    assign rd_st   = st_q[rd_idx];
    assign rd_tag  = tag_q[rd_idx];
    assign rd_data = data_q[rd_idx];

    always_comb begin
        snp_st  = st_q[snp_idx];
        snp_hit = snp_valid && (snp_st != LN_INV) && (tag_q[snp_idx] == snp_tag);
    end

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic sel_wr, sel_snp;
        assign sel_wr  = wr_en && (wr_idx == IDX_W'(g));
        assign sel_snp = snp_hit && (snp_idx == IDX_W'(g));
        always_ff @(posedge clk) begin
            if (rst) begin
                st_q[g]   <= LN_INV;
                tag_q[g]  <= '0;
                data_q[g] <= '0;
            end else if (sel_wr) begin
                st_q[g]   <= wr_st;
                tag_q[g]  <= wr_tag;
                data_q[g] <= wr_data;
            end else if (sel_snp) begin
                // write miss elsewhere kills the copy; read miss demotes a dirty owner
                if (snp_is_wr)
                    st_q[g] <= LN_INV;
                else if (st_q[g] == LN_EXC)
                    st_q[g] <= LN_SHR;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flush_valid <= 1'b0;
            flush_addr  <= '0;
            flush_data  <= '0;
        end else begin
            flush_valid <= snp_hit && (snp_st == LN_EXC);
            flush_addr  <= {snp_tag, snp_idx};
            flush_data  <= data_q[snp_idx];
        end
    end
endmodule

// File: rtl/snp_cpu_fsm.sv
`timescale 1ns/1ps
// Processor-side controller: lookup, pending bus states, line update.
module snp_cpu_fsm
    import snoop_coh_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int IDX_W  = 3,
    parameter int TAG_W  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_busy,
    output logic              cpu_done,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic [IDX_W-1:0]  ln_idx,
    input  line_st_e          ln_st,
    input  logic [TAG_W-1:0]  ln_tag,
    input  logic [DATA_W-1:0] ln_data,
    output logic              wr_en,
    output line_st_e          wr_st,
    output logic [TAG_W-1:0]  wr_tag,
    output logic [DATA_W-1:0] wr_data,
    input  logic              snp_valid,
    input  logic [IDX_W-1:0]  snp_idx,
    output logic              bus_req,
    output logic [1:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_gnt,
    input  logic [DATA_W-1:0] bus_rdata
);
    fsm_e              st_q, st_d;
    logic [ADDR_W-1:0] a_q;
    logic              we_q;
    logic [DATA_W-1:0] wd_q;
    logic              done_d;
    logic [DATA_W-1:0] rdata_d;

    logic [IDX_W-1:0] idx;
    logic [TAG_W-1:0] tag;
    logic snp_block, hit, dirty;
    fsm_e miss_next;

    assign idx       = a_q[IDX_W-1:0];
    assign tag       = a_q[ADDR_W-1:IDX_W];
    assign ln_idx    = idx;
    assign snp_block = snp_valid && (snp_idx == idx);
    assign hit       = (ln_st != LN_INV) && (ln_tag == tag);
    assign dirty     = (ln_st == LN_EXC);
    assign miss_next = we_q ? F_PEND_WM : F_PEND_RD;
    assign cpu_busy  = (st_q != F_IDLE);

    always_comb begin
        st_d      = st_q;
        wr_en     = 1'b0;
        wr_st     = LN_INV;
        wr_tag    = tag;
        wr_data   = wd_q;
        bus_req   = 1'b0;
        bus_cmd   = BC_IDLE;
        bus_addr  = a_q;
        bus_wdata = wd_q;
        done_d    = 1'b0;
        rdata_d   = cpu_rdata;
        unique case (st_q)
            F_IDLE: if (cpu_req) st_d = F_CHECK;
            F_CHECK: if (!snp_block) begin
                if (!we_q) begin
                    if (hit) begin
                        done_d  = 1'b1;
                        rdata_d = ln_data;
                        st_d    = F_IDLE;
                    end else begin
                        st_d = dirty ? F_PEND_WB : F_PEND_RD;
                    end
                end else if (hit && dirty) begin
                    wr_en  = 1'b1;
                    wr_st  = LN_EXC;
                    done_d = 1'b1;
                    st_d   = F_IDLE;
                end else if (hit) begin
                    st_d = F_PEND_WM;
                end else begin
                    st_d = dirty ? F_PEND_WB : F_PEND_WM;
                end
            end
            F_PEND_WB: begin
                bus_addr  = {ln_tag, idx};
                bus_wdata = ln_data;
                bus_cmd   = BC_WRBACK;
                if (!dirty) begin
                    // a snoop already flushed the victim
                    st_d = miss_next;
                end else begin
                    bus_req = !snp_block;
                    if (!snp_block && bus_gnt) begin
                        wr_en   = 1'b1;
                        wr_st   = LN_INV;
                        wr_tag  = ln_tag;
                        wr_data = ln_data;
                        st_d    = miss_next;
                    end
                end
            end
            F_PEND_RD: begin
                bus_cmd = BC_RDMISS;
                bus_req = !snp_block;
                if (!snp_block && bus_gnt) begin
                    wr_en   = 1'b1;
                    wr_st   = LN_SHR;
                    wr_data = bus_rdata;
                    done_d  = 1'b1;
                    rdata_d = bus_rdata;
                    st_d    = F_IDLE;
                end
            end
            F_PEND_WM: begin
                bus_cmd = BC_WRMISS;
                bus_req = !snp_block;
                if (!snp_block && bus_gnt) begin
                    wr_en  = 1'b1;
                    wr_st  = LN_EXC;
                    done_d = 1'b1;
                    st_d   = F_IDLE;
                end
            end
            default: st_d = F_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= F_IDLE;
            cpu_done  <= 1'b0;
            cpu_rdata <= '0;
            a_q       <= '0;
            we_q      <= 1'b0;
            wd_q      <= '0;
        end else begin
            st_q      <= st_d;
            cpu_done  <= done_d;
            cpu_rdata <= rdata_d;
            if (st_q == F_IDLE && cpu_req) begin
                a_q  <= cpu_addr;
                we_q <= cpu_we;
                wd_q <= cpu_wdata;
            end
        end
    end
endmodule

// File: rtl/snoop_coh_ctrl.sv
`timescale 1ns/1ps
module snoop_coh_ctrl
    import snoop_coh_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int LINES  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_busy,
    output logic              cpu_done,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              bus_req,
    output logic [1:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_gnt,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              snp_valid,
    input  logic              snp_is_wr,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              flush_valid,
    output logic [ADDR_W-1:0] flush_addr,
    output logic [DATA_W-1:0] flush_data
);
    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [IDX_W-1:0]  ln_idx;
    line_st_e          ln_st;
    logic [TAG_W-1:0]  ln_tag;
    logic [DATA_W-1:0] ln_data;
    logic              wr_en;
    line_st_e          wr_st;
    logic [TAG_W-1:0]  wr_tag;
    logic [DATA_W-1:0] wr_data;

    snp_line_array #(
        .LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)
    ) u_lines (
        .clk(clk), .rst(rst),
        .rd_idx(ln_idx), .rd_st(ln_st), .rd_tag(ln_tag), .rd_data(ln_data),
        .wr_en(wr_en), .wr_idx(ln_idx), .wr_st(wr_st), .wr_tag(wr_tag), .wr_data(wr_data),
        .snp_valid(snp_valid), .snp_is_wr(snp_is_wr),
        .snp_idx(snp_addr[IDX_W-1:0]), .snp_tag(snp_addr[ADDR_W-1:IDX_W]),
        .flush_valid(flush_valid), .flush_addr(flush_addr), .flush_data(flush_data)
    );

    snp_cpu_fsm #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .TAG_W(TAG_W)
    ) u_fsm (
        .clk(clk), .rst(rst),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_busy(cpu_busy), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
        .ln_idx(ln_idx), .ln_st(ln_st), .ln_tag(ln_tag), .ln_data(ln_data),
        .wr_en(wr_en), .wr_st(wr_st), .wr_tag(wr_tag), .wr_data(wr_data),
        .snp_valid(snp_valid), .snp_idx(snp_addr[IDX_W-1:0]),
        .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_gnt(bus_gnt), .bus_rdata(bus_rdata)
    );
endmodule

// File: rtl/snoop_coh_ctrl_chk.sv
`timescale 1ns/1ps
module snoop_coh_ctrl_chk #(
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              cpu_req,
    input logic              cpu_busy,
    input logic              cpu_done,
    input logic              bus_req,
    input logic [1:0]        bus_cmd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_gnt,
    input logic              snp_valid,
    input logic [ADDR_W-1:0] snp_addr,
    input logic              flush_valid
);
    a_r10_req_held: assert property (@(posedge clk) disable iff (rst)
        bus_req && !bus_gnt |=> bus_req || snp_valid);

    a_r10_cmd_stable: assert property (@(posedge clk) disable iff (rst)
        bus_req && !bus_gnt |=> $stable(bus_cmd) && $stable(bus_addr));

    a_r9_wb_then_miss: assert property (@(posedge clk) disable iff (rst)
        bus_req && bus_gnt && bus_cmd == 2'd3 |=> bus_cmd == 2'd1 || bus_cmd == 2'd2);

    a_r12_snoop_first: assert property (@(posedge clk) disable iff (rst)
        snp_valid && bus_req |-> bus_addr[IDX_W-1:0] != snp_addr[IDX_W-1:0]);

    a_r11_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
        cpu_req && !cpu_busy |=> cpu_busy);

    a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
        cpu_done |=> !cpu_done);

    a_r7_flush_needs_snoop: assert property (@(posedge clk) disable iff (rst)
        flush_valid |-> $past(snp_valid));
endmodule

bind snoop_coh_ctrl snoop_coh_ctrl_chk #(.ADDR_W(ADDR_W), .IDX_W($clog2(LINES))) u_chk (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_busy(cpu_busy), .cpu_done(cpu_done),
    .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_gnt(bus_gnt),
    .snp_valid(snp_valid), .snp_addr(snp_addr), .flush_valid(flush_valid)
);

// File: tb/snoop_coh_ctrl_bench.sv
`timescale 1ns/1ps
module snoop_coh_ctrl_bench;
    logic        clk = 1'b0, rst = 1'b1;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [7:0]  cpu_addr = '0;
    logic [15:0] cpu_wdata = '0;
    logic        cpu_busy, cpu_done;
    logic [15:0] cpu_rdata;
    logic        bus_req;
    logic [1:0]  bus_cmd;
    logic [7:0]  bus_addr;
    logic [15:0] bus_wdata;
    logic        bus_gnt = 1'b0;
    logic [15:0] bus_rdata = '0;
    logic        snp_valid = 1'b0, snp_is_wr = 1'b0;
    logic [7:0]  snp_addr = '0;
    logic        flush_valid;
    logic [7:0]  flush_addr;
    logic [15:0] flush_data;

    snoop_coh_ctrl u_snoop_coh_ctrl (.*);

    always #4 clk = ~clk;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    logic [1:0]  lg_cmd  [4];
    logic [7:0]  lg_addr [4];
    logic [15:0] lg_data [4];
    int          lg_n;
    logic [15:0] rd_res;

    // bus command codes: 1 read miss, 2 write miss, 3 write-back (R10)
    task automatic cpu_op(input logic we, input logic [7:0] a, input logic [15:0] wd,
                          input logic [15:0] fill);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        @(posedge clk); @(negedge clk);
        cpu_req = 1'b0;
        lg_n = 0;
        for (int k = 0; k < 40; k++) begin
            bus_gnt = 1'b0;
            if (cpu_done) break;
            if (!cpu_busy) check("R11 busy while pending", cpu_busy, 1);
            if (bus_req) begin
                if (lg_n < 4) begin
                    lg_cmd[lg_n] = bus_cmd; lg_addr[lg_n] = bus_addr; lg_data[lg_n] = bus_wdata;
                end
                lg_n++;
                bus_gnt = 1'b1; bus_rdata = fill;
            end
            @(posedge clk); @(negedge clk);
        end
        bus_gnt = 1'b0;
        check("R11 done pulse", cpu_done, 1);
        check("R11 busy low at done", cpu_busy, 0);
        rd_res = cpu_rdata;
    endtask

    task automatic snoop(input logic is_wr, input logic [7:0] a);
        @(negedge clk);
        snp_valid = 1'b1; snp_is_wr = is_wr; snp_addr = a;
        @(posedge clk); @(negedge clk);
        snp_valid = 1'b0;
    endtask

    typedef struct packed {
        logic [1:0]  kind;   // 0 read, 1 write, 2 snoop read miss, 3 snoop write miss
        logic [7:0]  addr;
        logic [15:0] wd;
        logic [15:0] fill;
        logic [1:0]  c0;     // first expected bus command (0 none)
        logic [1:0]  c1;     // second expected bus command
        logic [15:0] exp;    // read data, or flush data for snoops
        logic        fl;     // flush expected
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 8'h11, 16'h0000, 16'hA001, 2'd1, 2'd0, 16'hA001, 1'b0, 4'd2},  // R2
        '{2'd0, 8'h11, 16'h0000, 16'h0000, 2'd0, 2'd0, 16'hA001, 1'b0, 4'd4},  // R4
        '{2'd1, 8'h11, 16'hB002, 16'h0000, 2'd2, 2'd0, 16'h0000, 1'b0, 4'd3},  // R3
        '{2'd0, 8'h11, 16'h0000, 16'h0000, 2'd0, 2'd0, 16'hB002, 1'b0, 4'd4},  // R4
        '{2'd1, 8'h11, 16'hC003, 16'h0000, 2'd0, 2'd0, 16'h0000, 1'b0, 4'd4},  // R4
        '{2'd0, 8'h19, 16'h0000, 16'hD004, 2'd3, 2'd1, 16'hD004, 1'b0, 4'd9},  // R9
        '{2'd2, 8'h19, 16'h0000, 16'h0000, 2'd0, 2'd0, 16'h0000, 1'b0, 4'd6},  // R6
        '{2'd0, 8'h19, 16'h0000, 16'h0000, 2'd0, 2'd0, 16'hD004, 1'b0, 4'd6},  // R6
        '{2'd3, 8'h19, 16'h0000, 16'h0000, 2'd0, 2'd0, 16'h0000, 1'b0, 4'd5},  // R5
        '{2'd0, 8'h19, 16'h0000, 16'hE005, 2'd1, 2'd0, 16'hE005, 1'b0, 4'd5},  // R5
        '{2'd1, 8'h22, 16'hF006, 16'h0000, 2'd2, 2'd0, 16'h0000, 1'b0, 4'd3},  // R3
        '{2'd2, 8'h22, 16'h0000, 16'h0000, 2'd0, 2'd0, 16'hF006, 1'b1, 4'd7},  // R7
        '{2'd0, 8'h22, 16'h0000, 16'h0000, 2'd0, 2'd0, 16'hF006, 1'b0, 4'd7},  // R7
        '{2'd1, 8'h22, 16'h1007, 16'h0000, 2'd2, 2'd0, 16'h0000, 1'b0, 4'd7},  // R7
        '{2'd3, 8'h22, 16'h0000, 16'h0000, 2'd0, 2'd0, 16'h1007, 1'b1, 4'd8},  // R8
        '{2'd0, 8'h22, 16'h0000, 16'h2008, 2'd1, 2'd0, 16'h2008, 1'b0, 4'd8},  // R8
        '{2'd1, 8'h2A, 16'h3009, 16'h0000, 2'd2, 2'd0, 16'h0000, 1'b0, 4'd3}   // R3
    };

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog R11 actual=hung expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check("R1 busy", cpu_busy, 0);
        check("R1 bus_req", bus_req, 0);
        check("R1 flush", flush_valid, 0);
        check("R1 done", cpu_done, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 idle after release", {bus_req, cpu_busy, flush_valid}, 0);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            string tg;
            v  = VEC[i];
            tg = $sformatf("R%0d vec%0d", v.req, i);
            if (v.kind < 2) begin
                cpu_op(v.kind[0], v.addr, v.wd, v.fill);
                check({tg, " cmd0"}, (lg_n > 0) ? lg_cmd[0] : 2'd0, v.c0);
                check({tg, " cmd1"}, (lg_n > 1) ? lg_cmd[1] : 2'd0, v.c1);
                if (v.c0 == 2'd1 || v.c0 == 2'd2) check({tg, " addr"}, lg_addr[0], v.addr);
                if (v.kind == 2'd0) check({tg, " rdata"}, rd_res, v.exp);
            end else begin
                snoop(v.kind[0], v.addr);
                check({tg, " flush"}, flush_valid, v.fl);
                if (v.fl) begin
                    check({tg, " flush addr"}, flush_addr, v.addr);
                    check({tg, " flush data"}, flush_data, v.exp);
                end
            end
        end

        // R9: write-back carries the old address and data, then the miss
        cpu_op(1'b1, 8'h33, 16'hAAAA, 16'h0000);
        cpu_op(1'b0, 8'h3B, 16'h0000, 16'h5555);
        check("R9 wb cmd", lg_cmd[0], 2'd3);
        check("R9 wb addr", lg_addr[0], 8'h33);
        check("R9 wb data", lg_data[0], 16'hAAAA);
        check("R9 miss cmd", lg_cmd[1], 2'd1);
        check("R9 miss addr", lg_addr[1], 8'h3B);
        check("R9 rdata", rd_res, 16'h5555);

        // R12 / R10: snoop overtakes a waiting write-back on the same index
        cpu_op(1'b1, 8'h44, 16'h1234, 16'h0000);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 8'h4C;
        @(posedge clk); @(negedge clk);
        cpu_req = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R9 pending wb req", bus_req, 1);
        check("R10 wb cmd code", bus_cmd, 2'd3);
        check("R9 pending wb addr", bus_addr, 8'h44);
        @(posedge clk); @(negedge clk);
        check("R10 req held without grant", {bus_req, bus_cmd}, {1'b1, 2'd3});
        snp_valid = 1'b1; snp_is_wr = 1'b1; snp_addr = 8'h44;
        #1;
        check("R12 req yields to snoop", bus_req, 0);
        @(posedge clk); @(negedge clk);
        snp_valid = 1'b0;
        check("R8 flush on pending victim", flush_valid, 1);
        check("R8 flush addr", flush_addr, 8'h44);
        check("R8 flush data", flush_data, 16'h1234);
        @(posedge clk); @(negedge clk);
        check("R12 wb dropped, miss next", {bus_req, bus_cmd}, {1'b1, 2'd1});
        check("R12 miss addr", bus_addr, 8'h4C);
        bus_gnt = 1'b1; bus_rdata = 16'h7777;
        @(posedge clk); @(negedge clk);
        bus_gnt = 1'b0;
        check("R11 done after miss", cpu_done, 1);
        check("R2 fill returned", cpu_rdata, 16'h7777);

        finish_run();
    end
endmodule